// File: doc/BRIEF.md
# Clocked Async-Framed Serial Bridge

This block connects a host to a fast serial peripheral over three lines: a link clock that the bridge drives, a receive data line and a transmit data line. Data in both directions uses asynchronous framing: a low start bit, `DATA_W` payload bits with the least significant bit first, and a high stop bit. Each bit lasts one link clock. The peripheral changes receive data on the link rising edge and samples transmit data on the link rising edge. The link clock runs at half the system clock.

On the receive side, a completed frame is held in a one-entry output register. It is handed to the host through a valid/ready pair. While that register is full and the host has not taken it, the bridge halts the link clock, which stalls the peripheral's stream. The clock is only ever halted in its low phase and it restarts with a rising edge, so the clock-to-data phase never changes. On the transmit side, the host hands words into a one-entry holding register. A frame starts only while the clear-to-send input is high and only after a programmable minimum start-to-start spacing, counted in link clocks, has passed. This spacing defaults to 14.

Top module: `clkser_bridge`

## Requirements
- R1: During and after reset, `lclk` is low, `txd` is high, `rx_valid` is low, `tx_ready` is high and the start-to-start spacing is 14 link clocks.
- R2: While it is not halted, `lclk` is high for one system clock and low for one system clock, so its period is two system clocks.
- R3: A receive frame is a low start bit, then `DATA_W` bits with bit 0 first, then a stop bit. `rxd` is sampled on the system edge that ends each link high phase, and a frame with a high stop bit is presented on `rx_data` with `rx_valid` high until the cycle after `rx_ready` is seen high.
- R4: A receive frame whose stop bit is low is discarded, and `rx_valid` stays low.
- R5: While `rx_valid` is high and `rx_ready` is low, `lclk` stays low. Once the word is taken, the clock restarts and no frame is lost.
- R6: `lclk` is halted only in its low phase, so every high phase lasts exactly one system clock, including the first one after a halt.
- R7: A transmit frame is driven on `txd` as a low start bit, `DATA_W` bits with bit 0 first, and then a high stop bit. `txd` changes only on the system edge where `lclk` falls.
- R8: A frame starts only while `cts` is high. While a word waits for `cts`, `txd` stays high and `tx_ready` stays low.
- R9: Successive transmit start bits are at least the configured number of link clocks apart. When the host keeps the holding register full and that number is at least `DATA_W+2`, the spacing is exactly the configured number (14 after reset).
- R10: A write with `cfg_we` high loads `cfg_gap` as the new spacing. A value below `DATA_W+2` gives back-to-back frames spaced `DATA_W+2` link clocks apart.
- R11: Start bits are detected only at the receive sample points. A low level on `rxd` that lies entirely within a link low phase starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lclk | output | 1 | Link clock to the peripheral |
| rxd | input | 1 | Receive serial data from the peripheral |
| txd | output | 1 | Transmit serial data to the peripheral |
| cts | input | 1 | Clear-to-send from the peripheral, high permits a frame start |
| rx_data | output | DATA_W | Received word |
| rx_valid | output | 1 | Received word is available |
| rx_ready | input | 1 | Host takes the received word |
| tx_data | input | DATA_W | Word to transmit |
| tx_valid | input | 1 | Host offers a word |
| tx_ready | output | 1 | Holding register is empty |
| cfg_we | input | 1 | Load a new start-to-start spacing |
| cfg_gap | input | GAP_W | Spacing in link clocks |

## Verification
The assertions assume that the peripheral moves `rxd` only just after a link rising edge and never while the clock is halted. They also assume that the host leaves `cfg_gap` alone while a transmit burst is in flight, because the spacing check compares each start against the value in force at that moment. The bench peripheral drives `rxd` one nanosecond after each `lclk` rising edge and releases the line only after the stop-bit sample edge. It reprograms the spacing only between bursts, after all frames of the previous burst have been observed. The single glitch stimulus is placed entirely inside one low phase, so it tests the start detector without breaking the data-timing assumption.

// File: rtl/clkser_pkg.sv
package clkser_pkg;
   typedef enum logic [1:0] {
      RXS_IDLE = 2'd0,
      RXS_DATA = 2'd1,
      RXS_STOP = 2'd2
   } rx_state_t;
endpackage

// File: rtl/clkser_lclk_gen.sv
module clkser_lclk_gen (
   input  logic clk,
   input  logic rst,
   input  logic hold,
   output logic lclk,
   output logic strobe
);
   logic lclk_q;

   // High phase always ends after one cycle; a hold only keeps the low phase.
   always_ff @(posedge clk) begin
      if (rst)          lclk_q <= 1'b0;
      else if (lclk_q)  lclk_q <= 1'b0;
      else if (!hold)   lclk_q <= 1'b1;
   end

   assign lclk   = lclk_q;
   assign strobe = lclk_q;   // edge that ends the high phase: sample rx, advance tx
endmodule

// File: rtl/clkser_rx.sv
module clkser_rx
   import clkser_pkg::*;
#(
   parameter int DATA_W    = 9,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              smp,
   input  logic              rxd,
   input  logic              rx_ready,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              done
);
   localparam int CNT_W = $clog2(DATA_W + 1);

   rx_state_t         state;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] shreg_nxt;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign shreg_nxt = {rxd, shreg[DATA_W-1:1]};
      end else begin : g_msb
         assign shreg_nxt = {shreg[DATA_W-2:0], rxd};
      end
   endgenerate

   assign done = smp && (state == RXS_STOP) && rxd;

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= RXS_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         if (rx_valid && rx_ready) rx_valid <= 1'b0;
         if (smp) begin
            unique case (state)
               RXS_IDLE: if (!rxd) begin
                  state   <= RXS_DATA;
                  bit_cnt <= '0;
               end
               RXS_DATA: begin
                  shreg <= shreg_nxt;
                  if (bit_cnt == CNT_W'(DATA_W - 1)) state <= RXS_STOP;
                  else bit_cnt <= bit_cnt + 1'b1;
               end
               RXS_STOP: begin
                  state <= RXS_IDLE;
                  if (rxd) begin
                     rx_data  <= shreg;
                     rx_valid <= 1'b1;
                  end
               end
               default: state <= RXS_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/clkser_tx.sv
module clkser_tx #(
   parameter int DATA_W = 9,
   parameter int GAP_W  = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strobe,
   input  logic              cts,
   input  logic [GAP_W-1:0]  gap_cfg,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              txd,
   output logic              launch
);
   localparam int CNT_W = $clog2(DATA_W + 2);

   logic              buf_full;
   logic [DATA_W-1:0] buf_q;
   logic [DATA_W:0]   shreg;
   logic [CNT_W-1:0]  left;
   logic [GAP_W-1:0]  gap_cnt;

   assign tx_ready = !buf_full;
   assign launch   = strobe && (left == '0) && buf_full && cts && (gap_cnt >= gap_cfg);

   always_ff @(posedge clk) begin
      if (rst) begin
         buf_full <= 1'b0;
         buf_q    <= '0;
         shreg    <= '1;
         left     <= '0;
         txd      <= 1'b1;
         gap_cnt  <= '1;
      end else begin
         if (tx_valid && !buf_full) begin
            buf_q    <= tx_data;
            buf_full <= 1'b1;
         end
         if (launch) begin
            buf_full <= 1'b0;
            txd      <= 1'b0;
            shreg    <= {1'b1, buf_q};
            left     <= CNT_W'(DATA_W + 1);
            gap_cnt  <= GAP_W'(1);
         end else if (strobe) begin
            if (left != '0) begin
               txd   <= shreg[0];
               shreg <= {1'b1, shreg[DATA_W:1]};
               left  <= left - 1'b1;
            end
            if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/clkser_bridge.sv
module clkser_bridge #(
   parameter int DATA_W       = 9,
   parameter int GAP_W        = 5,
   parameter int GAP_RESET    = 14,
   parameter bit RX_LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic              lclk,
   input  logic              rxd,
   output logic              txd,
   input  logic              cts,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic              cfg_we,
   input  logic [GAP_W-1:0]  cfg_gap
);
   generate
      if (DATA_W < 2 || DATA_W > 32) begin : g_bad_width
         $error("clkser_bridge: DATA_W must lie in 2..32");
      end
      if (GAP_RESET < 0 || GAP_RESET >= (1 << GAP_W)) begin : g_bad_gap
         $error("clkser_bridge: GAP_RESET does not fit in GAP_W bits");
      end
   endgenerate

   logic             strobe;
   logic             hold;
   logic             rx_done;
   logic             tx_launch;
   logic [GAP_W-1:0] gap_q;

   assign hold = rx_valid && !rx_ready;

   always_ff @(posedge clk) begin
      if (rst)         gap_q <= GAP_W'(GAP_RESET);
      else if (cfg_we) gap_q <= cfg_gap;
   end

   clkser_lclk_gen u_clk (
      .clk   (clk),
      .rst   (rst),
      .hold  (hold),
      .lclk  (lclk),
      .strobe(strobe)
   );

   clkser_rx #(.DATA_W(DATA_W), .LSB_FIRST(RX_LSB_FIRST)) u_rx (
      .clk     (clk),
      .rst     (rst),
      .smp     (strobe),
      .rxd     (rxd),
      .rx_ready(rx_ready),
      .rx_data (rx_data),
      .rx_valid(rx_valid),
      .done    (rx_done)
   );

   clkser_tx #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_tx (
      .clk     (clk),
      .rst     (rst),
      .strobe  (strobe),
      .cts     (cts),
      .gap_cfg (gap_q),
      .tx_data (tx_data),
      .tx_valid(tx_valid),
      .tx_ready(tx_ready),
      .txd     (txd),
      .launch  (tx_launch)
   );
endmodule

// File: rtl/clkser_bridge_chk.sv
module clkser_bridge_chk #(
   parameter int GAP_W = 5
) (
   input logic             clk,
   input logic             rst,
   input logic             lclk,
   input logic             txd,
   input logic             cts,
   input logic             rx_valid,
   input logic             rx_ready,
   input logic             rx_done,
   input logic             tx_launch,
   input logic [GAP_W-1:0] gap_q
);
   logic [GAP_W-1:0] high_cnt;

   // Link high phases seen since the last frame start, saturating.
   always_ff @(posedge clk) begin
      if (rst)                          high_cnt <= '1;
      else if (tx_launch)               high_cnt <= '0;
      else if (lclk && high_cnt != '1)  high_cnt <= high_cnt + 1'b1;
   end

   a_r6_high_one_cycle: assert property (@(posedge clk) disable iff (rst)
      lclk |=> !lclk);

   a_r5_halt_low: assert property (@(posedge clk) disable iff (rst)
      (!lclk && rx_valid && !rx_ready) |=> !lclk);

   a_r5_no_overrun: assert property (@(posedge clk) disable iff (rst)
      rx_done |-> !(rx_valid && !rx_ready));

   a_r7_txd_on_fall: assert property (@(posedge clk) disable iff (rst)
      !$stable(txd) |-> $past(lclk));

   a_r8_cts_gate: assert property (@(posedge clk) disable iff (rst)
      tx_launch |-> cts);

   a_r9_min_gap: assert property (@(posedge clk) disable iff (rst)
      tx_launch |-> (({1'b0, high_cnt} + 1'b1) >= {1'b0, gap_q}));
endmodule

bind clkser_bridge clkser_bridge_chk #(.GAP_W(GAP_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .lclk     (lclk),
   .txd      (txd),
   .cts      (cts),
   .rx_valid (rx_valid),
   .rx_ready (rx_ready),
   .rx_done  (rx_done),
   .tx_launch(tx_launch),
   .gap_q    (gap_q)
);

// File: tb/clkser_bridge_tb_top.sv
`timescale 1ns/1ps
module clkser_bridge_tb_top;
   localparam int DW = 9;
   localparam int GW = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          lclk;
   logic          rxd = 1'b1;
   logic          txd;
   logic          cts = 1'b1;
   logic [DW-1:0] rx_data;
   logic          rx_valid;
   logic          rx_ready = 1'b0;
   logic [DW-1:0] tx_data = '0;
   logic          tx_valid = 1'b0;
   logic          tx_ready;
   logic          cfg_we = 1'b0;
   logic [GW-1:0] cfg_gap = '0;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done_f = 0;

   always #10 clk = ~clk;

   clkser_bridge #(.DATA_W(DW), .GAP_W(GW), .GAP_RESET(14)) dut_i (
      .clk(clk), .rst(rst), .lclk(lclk), .rxd(rxd), .txd(txd), .cts(cts),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .cfg_we(cfg_we), .cfg_gap(cfg_gap)
   );

   // {stop bit, payload}; a good frame is expected exactly when stop is 1
   localparam logic [DW:0] RXV [0:5] = '{
      {1'b1, 9'h000}, {1'b1, 9'h1FF}, {1'b1, 9'h0A5},
      {1'b0, 9'h05A}, {1'b1, 9'h155}, {1'b1, 9'h001}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Peripheral-side transmit monitor: samples txd on each link rising edge
   int            rise_cnt = 0;
   bit            m_busy = 0;
   int            m_idx = 0;
   int            m_start = 0;
   logic [DW-1:0] m_dat;
   logic [DW-1:0] got_d [0:31];
   int            got_s [0:31];
   bit            got_ok [0:31];
   int            nfr = 0;

   always @(posedge lclk) begin
      if (!m_busy) begin
         if (txd === 1'b0) begin
            m_busy = 1; m_idx = 0; m_start = rise_cnt;
         end
      end else if (m_idx < DW) begin
         m_dat[m_idx] = txd;
         m_idx++;
      end else begin
         if (nfr < 32) begin
            got_d[nfr] = m_dat; got_s[nfr] = m_start; got_ok[nfr] = (txd === 1'b1);
            nfr++;
         end
         m_busy = 0;
      end
      rise_cnt++;
   end

   task automatic send_rx(input logic [DW-1:0] d, input logic stop);
      @(posedge lclk); #1 rxd = 1'b0;
      for (int i = 0; i < DW; i++) begin
         @(posedge lclk); #1 rxd = d[i];
      end
      @(posedge lclk); #1 rxd = stop;
      @(negedge lclk); #1 rxd = 1'b1;
   endtask

   task automatic push(input logic [DW-1:0] d);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_valid = 1'b1; tx_data = d;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic set_gap(input logic [GW-1:0] g);
      @(negedge clk); cfg_we = 1'b1; cfg_gap = g;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic wait_frames(input int n);
      int t = 0;
      while (nfr < n && t < 5000) begin
         @(posedge clk); t++;
      end
   endtask

   task automatic burst_check(input int gap, input string req);
      int base;
      logic [DW-1:0] vals [0:3];
      vals[0] = 9'h001; vals[1] = 9'h100; vals[2] = 9'h0FF; vals[3] = 9'h155;
      base = nfr;
      for (int i = 0; i < 4; i++) push(vals[i]);
      wait_frames(base + 4);
      chk(nfr == base + 4, req, "burst frame count", nfr - base, 4);
      for (int i = 0; i < 4; i++) begin
         chk(got_d[base+i] == vals[i], "R7", "burst data", got_d[base+i], vals[i]);
         if (i > 0)
            chk(got_s[base+i] - got_s[base+i-1] == gap, req, "start spacing",
                got_s[base+i] - got_s[base+i-1], gap);
      end
   endtask

   initial begin
      real t0;
      bit  hold_ok;
      int  wcnt;
      int  base;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(lclk == 1'b0, "R1", "lclk in reset", lclk, 0);
      chk(txd == 1'b1, "R1", "txd in reset", txd, 1);
      chk(rx_valid == 1'b0, "R1", "rx_valid in reset", rx_valid, 0);
      chk(tx_ready == 1'b1, "R1", "tx_ready in reset", tx_ready, 1);
      rst = 1'b0;

      // R2: running period is two system clocks
      @(posedge lclk); t0 = $realtime;
      @(posedge lclk);
      chk(($realtime - t0) == 40.0, "R2", "lclk period ns", int'($realtime - t0), 40);

      // R3/R4/R5: receive vector table
      foreach (RXV[k]) begin
         send_rx(RXV[k][DW-1:0], RXV[k][DW]);
         repeat (4) @(negedge clk);
         if (RXV[k][DW]) begin
            chk(rx_valid == 1'b1, "R3", "rx_valid after frame", rx_valid, 1);
            chk(rx_data == RXV[k][DW-1:0], "R3", "rx_data", rx_data, RXV[k][DW-1:0]);
            hold_ok = 1;
            repeat (8) begin
               @(negedge clk);
               if (lclk !== 1'b0) hold_ok = 0;
            end
            chk(hold_ok, "R5", "lclk held low while word pending", hold_ok, 1);
            rx_ready = 1'b1;
            @(negedge clk); rx_ready = 1'b0;
            chk(rx_valid == 1'b0, "R3", "rx_valid after take", rx_valid, 0);
            if (k == 0) begin
               // R6: restart with a rising edge and a one-cycle high phase
               wcnt = 0;
               while (lclk !== 1'b1 && wcnt < 4) begin @(negedge clk); wcnt++; end
               chk(lclk == 1'b1 && wcnt <= 1, "R6", "cycles to restart", wcnt, 1);
               @(negedge clk);
               chk(lclk == 1'b0, "R6", "high phase after restart", lclk, 0);
            end
         end else begin
            chk(rx_valid == 1'b0, "R4", "bad stop discarded", rx_valid, 0);
         end
      end

      // R11: low pulse inside a low phase is ignored
      @(negedge lclk); #1 rxd = 1'b0;
      @(posedge lclk); #1 rxd = 1'b1;
      repeat (40) @(negedge clk);
      chk(rx_valid == 1'b0, "R11", "no frame from glitch", rx_valid, 0);
      send_rx(9'h0F0, 1'b1);
      repeat (4) @(negedge clk);
      chk(rx_valid == 1'b1 && rx_data == 9'h0F0, "R11", "frame after glitch", rx_data, 9'h0F0);
      rx_ready = 1'b1;

      // R7: single transmit frame
      base = nfr;
      push(9'h1A5);
      wait_frames(base + 1);
      chk(got_d[base] == 9'h1A5, "R7", "tx data", got_d[base], 9'h1A5);
      chk(got_ok[base], "R7", "tx stop bit", got_ok[base], 1);

      // R9: reset spacing, back to back
      burst_check(14, "R9");

      // R10: larger spacing, then spacing below frame length
      set_gap(5'd20);
      burst_check(20, "R10");
      set_gap(5'd5);
      burst_check(DW + 2, "R10");
      set_gap(5'd11);
      burst_check(DW + 2, "R9");

      // R8: clear-to-send gating
      cts = 1'b0;
      base = nfr;
      push(9'h0C3);
      repeat (80) @(negedge clk);
      chk(nfr == base, "R8", "no frame while cts low", nfr - base, 0);
      chk(txd == 1'b1, "R8", "txd idle while cts low", txd, 1);
      chk(tx_ready == 1'b0, "R8", "word held while cts low", tx_ready, 0);
      cts = 1'b1;
      wait_frames(base + 1);
      chk(nfr == base + 1 && got_d[base] == 9'h0C3, "R8", "frame after cts", got_d[base], 9'h0C3);

      done_f = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_f) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule